// File: doc/BRIEF.md
# Coalescing Set-Associative Translation Cache

This block caches virtual-to-physical page translations in a four-way set-associative array. Each entry covers a short run of up to four contiguous pages, all inside one naturally aligned group of four virtual pages. The physical pages of the run are also contiguous, so one entry stands in for as many as four ordinary translation entries. A coalescer upstream builds such runs and writes them in through a single fill port. The lookup port takes a virtual page number and reports, one clock later, whether it hit and which physical page it maps to.

The set index is taken from the virtual page number above its two lowest bits, so every page of an aligned group of four lands in the same set. On a lookup the cache compares tags in that set. It then checks that the two low page bits fall inside the stored run. If they do, it adds their distance from the run's first page to the stored base physical page. Runs are merged when an entry is written, never when it is read. Victims are chosen by a tree pseudo-LRU per set, and a flush input drops every entry at once.

Top module: `coalescing_tlb`

## Requirements
- R1: After reset `rsp_valid` and `rsp_hit` are 0, and every lookup misses until a fill is accepted.
- R2: The set index is `vpn[SET_W+1:2]` and the tag is `vpn[VPN_W-1:SET_W+2]`. The four pages of an aligned group share a set. A stored entry hits only when its tag matches, so a page whose tag differs misses even when its set and low bits do match.
- R3: With stored start `s` (the fill's `vpn[1:0]`) and length `n`, a lookup whose low bits `o` satisfy `s <= o < s+n` hits, and any other `o` misses.
- R4: On a hit `rsp_ppn` equals the stored base physical page plus `(o - s)`. On a miss `rsp_ppn` is 0.
- R5: `rsp_valid` is high in exactly the cycle after a cycle with `lk_valid` high. `rsp_hit` is never high without `rsp_valid`.
- R6: A fill is accepted only when `1 <= fl_len <= 4` and `s + fl_len <= 4`. Any other fill changes no entry.
- R7: A fill whose page range overlaps a valid entry with the same tag in the same set overwrites that entry. A fill that overlaps no such entry leaves the existing entries intact.
- R8: A fill with no overlap takes the lowest-numbered invalid way. If all four ways are valid, it takes the way named by the set's tree pseudo-LRU bits. The root bit picks the pair: 0 means ways 0/1 and 1 means ways 2/3. The selected pair's bit then picks the lower way on 0 and the upper way on 1. A fill or hit on a way points the root and that way's pair bit away from it.
- R9: A lookup in the same cycle as a fill to the same set is answered from the contents held before the fill, and the fill's replacement update takes priority over the lookup's.
- R10: `flush` invalidates every entry in one cycle, and it overrides a fill presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| rsp_valid | output | 1 | Registered response strobe |
| rsp_hit | output | 1 | Lookup hit |
| rsp_ppn | output | PPN_W | Translated physical page number |
| fl_valid | input | 1 | Fill request |
| fl_vpn | input | VPN_W | First virtual page of the run (low two bits give the start) |
| fl_len | input | 3 | Number of pages in the run |
| fl_ppn | input | PPN_W | Physical page of the run's first page |

## Verification
The bench builds the block with its defaults of 20-bit virtual and physical page numbers and 16 sets, which leaves a 14-bit tag. With these values a set can be filled to all four ways using pages that differ only in their tags. That makes the pseudo-LRU victim order observable through lookups alone. The small set count also lets separate scenarios use separate sets, so that earlier scenarios leave no stale state behind.

// File: rtl/coalescing_tlb.sv
module coalescing_tlb #(
  parameter int VPN_W = 20,
  parameter int PPN_W = 20,
  parameter int SET_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [PPN_W-1:0] rsp_ppn,
  input  logic             fl_valid,
  input  logic [VPN_W-1:0] fl_vpn,
  input  logic [2:0]       fl_len,
  input  logic [PPN_W-1:0] fl_ppn
);
  localparam int SETS  = 1 << SET_W;
  localparam int WAYS  = 4;
  localparam int TAG_W = VPN_W - SET_W - 2;

  logic [SETS-1:0][WAYS-1:0] vld_q;
  logic [SETS-1:0][2:0]      plru_q;
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [1:0]       st_q  [SETS][WAYS];
  logic [2:0]       len_q [SETS][WAYS];
  logic [PPN_W-1:0] ppn_q [SETS][WAYS];

  function automatic logic [2:0] plru_touch(input logic [2:0] b, input logic [1:0] w);
    logic [2:0] r;
    r = b;
    if (w[1] == 1'b0) begin
      r[0] = 1'b1;
      r[1] = ~w[0];
    end else begin
      r[0] = 1'b0;
      r[2] = ~w[0];
    end
    return r;
  endfunction

  logic [SET_W-1:0] lk_idx, fl_idx;
  logic [TAG_W-1:0] lk_tag, fl_tag;
  logic [1:0]       lk_off, fl_st;
  logic [3:0]       fl_lo, fl_hi;

  assign lk_idx = lk_vpn[SET_W+1:2];
  assign lk_tag = lk_vpn[VPN_W-1:SET_W+2];
  assign lk_off = lk_vpn[1:0];
  assign fl_idx = fl_vpn[SET_W+1:2];
  assign fl_tag = fl_vpn[VPN_W-1:SET_W+2];
  assign fl_st  = fl_vpn[1:0];
  assign fl_lo  = {2'b00, fl_st};
  assign fl_hi  = fl_lo + {1'b0, fl_len};

  logic fl_ok;
  assign fl_ok = fl_valid && (fl_len != 3'd0) && (fl_hi <= 4'd4);

  logic             lk_hit;
  logic [1:0]       lk_way;
  logic [PPN_W-1:0] lk_ppn;

  always_comb begin
    lk_hit = 1'b0;
    lk_way = 2'd0;
    lk_ppn = '0;
    for (int w = 0; w < WAYS; w++) begin
      logic [3:0] lo, hi, o;
      lo = {2'b00, st_q[lk_idx][w]};
      hi = lo + {1'b0, len_q[lk_idx][w]};
      o  = {2'b00, lk_off};
      if (!lk_hit && vld_q[lk_idx][w] && tag_q[lk_idx][w] == lk_tag && o >= lo && o < hi) begin
        lk_hit = 1'b1;
        lk_way = 2'(w);
        lk_ppn = ppn_q[lk_idx][w] + PPN_W'(lk_off - st_q[lk_idx][w]);
      end
    end
  end

  logic       ov_hit, inv_hit;
  logic [1:0] ov_way, inv_way, lru_way, vic;
  logic [2:0] fb;

  assign fb      = plru_q[fl_idx];
  assign lru_way = fb[0] ? (fb[2] ? 2'd3 : 2'd2) : (fb[1] ? 2'd1 : 2'd0);

  always_comb begin
    ov_hit  = 1'b0;
    ov_way  = 2'd0;
    inv_hit = 1'b0;
    inv_way = 2'd0;
    for (int w = 0; w < WAYS; w++) begin
      logic [3:0] lo, hi;
      lo = {2'b00, st_q[fl_idx][w]};
      hi = lo + {1'b0, len_q[fl_idx][w]};
      if (!ov_hit && vld_q[fl_idx][w] && tag_q[fl_idx][w] == fl_tag && lo < fl_hi && fl_lo < hi) begin
        ov_hit = 1'b1;
        ov_way = 2'(w);
      end
      if (!inv_hit && !vld_q[fl_idx][w]) begin
        inv_hit = 1'b1;
        inv_way = 2'(w);
      end
    end
  end

  assign vic = ov_hit ? ov_way : (inv_hit ? inv_way : lru_way);

  logic do_fill;
  assign do_fill = fl_ok && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q     <= '0;
      plru_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_ppn   <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && lk_hit;
      rsp_ppn   <= (lk_valid && lk_hit) ? lk_ppn : '0;
      if (flush)        vld_q <= '0;
      else if (do_fill) vld_q[fl_idx][vic] <= 1'b1;
      if (lk_valid && lk_hit && !(do_fill && fl_idx == lk_idx))
        plru_q[lk_idx] <= plru_touch(plru_q[lk_idx], lk_way);
      if (do_fill)
        plru_q[fl_idx] <= plru_touch(plru_q[fl_idx], vic);
    end
  end

  always_ff @(posedge clk) begin
    if (do_fill) begin
      tag_q[fl_idx][vic] <= fl_tag;
      st_q[fl_idx][vic]  <= fl_st;
      len_q[fl_idx][vic] <= fl_len;
      ppn_q[fl_idx][vic] <= fl_ppn;
    end
  end

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n) lk_valid |=> rsp_valid); // R5
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n) !lk_valid |=> !rsp_valid); // R5
  AST_HIT_NEEDS_RSP: assert property (@(posedge clk) disable iff (!rst_n) rsp_hit |-> rsp_valid); // R5
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) flush |=> (vld_q == '0)); // R10
  AST_BAD_FILL_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_valid && !fl_ok && !flush) |=> $stable(vld_q)); // R6
  AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_ok && !flush) |=> ($countones(vld_q) != 0)); // R7
endmodule

// File: tb/tb_coalescing_tlb.sv
`timescale 1ns/1ps
module tb_coalescing_tlb;
  localparam int VPN_W = 20;
  localparam int PPN_W = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic lk_valid = 1'b0;
  logic [VPN_W-1:0] lk_vpn = '0;
  logic rsp_valid, rsp_hit;
  logic [PPN_W-1:0] rsp_ppn;
  logic fl_valid = 1'b0;
  logic [VPN_W-1:0] fl_vpn = '0;
  logic [2:0] fl_len = '0;
  logic [PPN_W-1:0] fl_ppn = '0;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  coalescing_tlb #(.VPN_W(VPN_W), .PPN_W(PPN_W), .SET_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn),
    .fl_valid(fl_valid), .fl_vpn(fl_vpn), .fl_len(fl_len), .fl_ppn(fl_ppn));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic lookup(input logic [VPN_W-1:0] v, input bit hit, input logic [PPN_W-1:0] ppn, input string req);
    @(negedge clk);
    lk_valid = 1'b1;
    lk_vpn = v;
    @(negedge clk);
    lk_valid = 1'b0;
    check(rsp_valid == 1'b1, {req, " rsp_valid"}, rsp_valid, 1);
    check(rsp_hit == hit, {req, " hit"}, rsp_hit, hit);
    check(rsp_ppn == (hit ? ppn : '0), {req, " ppn"}, rsp_ppn, hit ? ppn : 0);
  endtask

  task automatic fill(input logic [VPN_W-1:0] v, input logic [2:0] n, input logic [PPN_W-1:0] p);
    @(negedge clk);
    fl_valid = 1'b1;
    fl_vpn = v;
    fl_len = n;
    fl_ppn = p;
    @(negedge clk);
    fl_valid = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic t_reset();
    check(rsp_valid == 1'b0, "R1 rsp_valid after reset", rsp_valid, 0);
    check(rsp_hit == 1'b0, "R1 rsp_hit after reset", rsp_hit, 0);
    lookup(20'h00120, 1'b0, '0, "R1 empty lookup");
    @(negedge clk);
    check(rsp_valid == 1'b0, "R5 no rsp without request", rsp_valid, 0);
  endtask

  task automatic t_range();
    fill(20'h00121, 3'd3, 20'h00500);
    lookup(20'h00120, 1'b0, '0, "R3 below start");
    lookup(20'h00121, 1'b1, 20'h00500, "R4 offset 0");
    lookup(20'h00122, 1'b1, 20'h00501, "R4 offset 1");
    lookup(20'h00123, 1'b1, 20'h00502, "R2 R4 offset 2 same set");
    lookup(20'h00161, 1'b0, '0, "R2 other tag same set");
    lookup(20'h00125, 1'b0, '0, "R2 other set");
  endtask

  task automatic t_overlap();
    fill(20'h00122, 3'd2, 20'h00700);
    lookup(20'h00121, 1'b0, '0, "R7 overlapped entry replaced");
    lookup(20'h00123, 1'b1, 20'h00701, "R7 new entry");
    fill(20'h00120, 3'd1, 20'h00900);
    lookup(20'h00120, 1'b1, 20'h00900, "R7 disjoint allocate");
    lookup(20'h00122, 1'b1, 20'h00700, "R7 disjoint keeps old");
  endtask

  task automatic t_illegal();
    fill(20'h00230, 3'd0, 20'h00AAA);
    lookup(20'h00230, 1'b0, '0, "R6 zero length ignored");
    fill(20'h00233, 3'd2, 20'h00BBB);
    lookup(20'h00233, 1'b0, '0, "R6 crossing group ignored");
    fill(20'h00230, 3'd5, 20'h00CCC);
    lookup(20'h00231, 1'b0, '0, "R6 length 5 ignored");
  endtask

  task automatic t_plru();
    do_flush();
    fill(20'h0000C, 3'd4, 20'h01000);
    fill(20'h0004C, 3'd4, 20'h02000);
    fill(20'h0008C, 3'd4, 20'h03000);
    fill(20'h000CC, 3'd4, 20'h04000);
    lookup(20'h0000D, 1'b1, 20'h01001, "R8 way0 hit");
    fill(20'h0010C, 3'd4, 20'h05000);
    lookup(20'h0008E, 1'b0, '0, "R8 plru victim way2 evicted");
    lookup(20'h0010F, 1'b1, 20'h05003, "R8 new entry");
    lookup(20'h0000C, 1'b1, 20'h01000, "R8 way0 kept");
    lookup(20'h0004C, 1'b1, 20'h02000, "R8 way1 kept");
    lookup(20'h000CC, 1'b1, 20'h04000, "R8 way3 kept");
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    fl_valid = 1'b1;
    fl_vpn = 20'h00340;
    fl_len = 3'd4;
    fl_ppn = 20'h06000;
    lk_valid = 1'b1;
    lk_vpn = 20'h00342;
    @(negedge clk);
    fl_valid = 1'b0;
    lk_valid = 1'b0;
    check(rsp_hit == 1'b0, "R9 lookup sees pre-fill contents", rsp_hit, 0);
    lookup(20'h00342, 1'b1, 20'h06002, "R9 fill landed");
  endtask

  task automatic t_flush();
    do_flush();
    lookup(20'h00342, 1'b0, '0, "R10 flushed");
    lookup(20'h0010F, 1'b0, '0, "R10 flushed set 3");
    @(negedge clk);
    flush = 1'b1;
    fl_valid = 1'b1;
    fl_vpn = 20'h00400;
    fl_len = 3'd1;
    fl_ppn = 20'h07000;
    @(negedge clk);
    flush = 1'b0;
    fl_valid = 1'b0;
    lookup(20'h00400, 1'b0, '0, "R10 flush overrides fill");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_range();
    t_overlap();
    t_illegal();
    t_plru();
    t_same_cycle();
    t_flush();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule